// File: doc/BRIEF.md
# Sequential Shift-Add Fraction Multiplier

This block multiplies two sign-magnitude operands. Each operand has a 35-bit unsigned magnitude, supplied as a 17-bit upper part and an 18-bit lower part, together with a separate sign bit and an 18-bit two's complement exponent. The multiplication runs one shift-add step per clock. The partial product builds up in an accumulator that is joined to an extension register, so the two together hold the full 70-bit product.

In floating mode the block adds the exponents and can normalize the 70-bit product. It then rounds from the top bit of the extension register and reports exponent range faults. In integer mode the low 35 bits of the product are the result. The upper 35 bits go to the extension output, and any nonzero upper bit there is flagged as overflow.

A single-cycle start pulse, given while the block is idle, captures the operands and the mode controls. A one-cycle done pulse shows that the result and status outputs are valid. The outputs then hold their values until the next done pulse.

Top module: `fmul_seq`

## Requirements
- R1: After reset, busy_o, done_o, every result field, guard_o, ovf_o and unf_o are all zero.
- R2: start_i is accepted only when busy_o is low, and busy_o is high in the cycle after an accepted start. A start_i given while busy_o is high has no effect: the running operation's result, status and done timing are unchanged.
- R3: done_o is high for exactly one cycle, and busy_o is low in that cycle. The result outputs change only at the edge that raises done_o.
- R4: Count the rising edges after the accepting edge. When both magnitudes are nonzero, done_o rises after edge 36 in integer mode. In floating mode it rises after edge 37+S, where S is the number of normalize shifts (0 when normalization is disabled). When either magnitude is zero, done_o rises after edge 1 in integer mode and after edge 2 in floating mode.
- R5: The result sign is the XOR of the two operand signs. Each magnitude is {hi, lo}, with hi as the upper 17 bits, and the 70-bit unsigned product P is formed from the two magnitudes.
- R6: In integer mode, {res_hi_o, res_lo_o} = P[34:0] and {ext_hi_o, ext_lo_o} = P[69:35]. ovf_o is high exactly when P[69:35] is nonzero, and res_exp_o, guard_o and unf_o are zero.
- R7: In floating mode the exponent starts as the sign-extended sum of the two exponents. Unless no_norm_i is set, the product is shifted left one place at a time, and the exponent decremented each time, until bit 69 is 1. This continues only while the product is nonzero.
- R8: In floating mode with normalization enabled, a zero product gives res_sign_o = 0 and res_exp_o = 0. With normalization disabled, the sign and exponent sum are kept.
- R9: In floating mode, ext_hi_o[16] (product bit 34 after normalization) sets guard_o. Unless no_round_i is set, this also adds 1 to the 35-bit result. If that increment carries out, the result becomes res_hi_o = 1<<16 with res_lo_o = 0, and the exponent increases by 1.
- R10: In floating mode, ovf_o is set when the final exponent is above +131071 and unf_o when it is below -131072. res_exp_o carries the low 18 bits of the final exponent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, taken only when idle |
| float_i | input | 1 | 1 = floating mode, 0 = integer mode |
| no_norm_i | input | 1 | Skip normalization |
| no_round_i | input | 1 | Skip the rounding increment |
| a_sign_i | input | 1 | Sign of operand A |
| a_hi_i | input | 17 | Upper magnitude part of A |
| a_lo_i | input | 18 | Lower magnitude part of A |
| a_exp_i | input | 18 | Exponent of A, two's complement |
| b_sign_i | input | 1 | Sign of operand B |
| b_hi_i | input | 17 | Upper magnitude part of B |
| b_lo_i | input | 18 | Lower magnitude part of B |
| b_exp_i | input | 18 | Exponent of B, two's complement |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| res_sign_o | output | 1 | Result sign |
| res_hi_o | output | 17 | Result magnitude, upper part |
| res_lo_o | output | 18 | Result magnitude, lower part |
| res_exp_o | output | 18 | Result exponent |
| ext_hi_o | output | 17 | Extension register, upper part |
| ext_lo_o | output | 18 | Extension register, lower part |
| guard_o | output | 1 | A round was due |
| ovf_o | output | 1 | Overflow |
| unf_o | output | 1 | Underflow |

## Verification
The bench runs a product whose normalized upper half is all ones with a set extension top bit. A design that mishandles the round carry would return zero or an unnormalized fraction instead of one-half with the exponent bumped. Zero operands are run with normalization both on and off. A design that forces sign and exponent in the wrong case, or still spends 35 steps, shows a wrong field or a wrong done cycle. Exponent sums just past both range limits are also checked, along with an integer product whose upper half is nonzero; these catch off-by-one limits and a check made on the wrong half. Finally, a second start is pulsed mid-operation with different operands, which exposes any design that restarts or relatches.

// File: rtl/fmul_pkg.sv
package fmul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MUL,
    ST_NORM,
    ST_RND
  } fmul_state_e;
endpackage

// File: rtl/fmul_step.sv
// One shift-add iteration over the joined accumulator and extension register.
module fmul_step #(
  parameter int FRAC_W = 35
) (
  input  logic [FRAC_W-1:0] acc_i,
  input  logic [FRAC_W-1:0] ext_i,
  input  logic [FRAC_W-1:0] mcand_i,
  output logic [FRAC_W-1:0] acc_o,
  output logic [FRAC_W-1:0] ext_o
);
  logic [FRAC_W:0] sum;

  always_comb begin
    sum   = {1'b0, acc_i} + (ext_i[0] ? {1'b0, mcand_i} : '0);
    acc_o = sum[FRAC_W:1];
    ext_o = {sum[0], ext_i[FRAC_W-1:1]};
  end
endmodule

// File: rtl/fmul_round.sv
// Round from the extension MSB, then check the exponent range.
module fmul_round #(
  parameter int FRAC_W = 35,
  parameter int EXP_W  = 18,
  parameter int XW     = EXP_W + 2
) (
  input  logic [FRAC_W-1:0]    frac_i,
  input  logic                 ext_msb_i,
  input  logic signed [XW-1:0] exp_i,
  input  logic                 no_round_i,
  output logic [FRAC_W-1:0]    frac_o,
  output logic signed [XW-1:0] exp_o,
  output logic                 guard_o,
  output logic                 ovf_o,
  output logic                 unf_o
);
  localparam int EXP_MAX_I = 2 ** (EXP_W - 1) - 1;
  localparam int EXP_MIN_I = -(2 ** (EXP_W - 1));

  logic [FRAC_W:0]      inc;
  logic signed [XW-1:0] exp_max, exp_min;

  assign exp_max = XW'(EXP_MAX_I);
  assign exp_min = XW'(EXP_MIN_I);

  always_comb begin
    inc     = {1'b0, frac_i} + 1'b1;
    frac_o  = frac_i;
    exp_o   = exp_i;
    guard_o = ext_msb_i;
    if (ext_msb_i && !no_round_i) begin
      if (inc[FRAC_W]) begin
        frac_o = {1'b1, {(FRAC_W-1){1'b0}}};
        exp_o  = exp_i + XW'(1);
      end else begin
        frac_o = inc[FRAC_W-1:0];
      end
    end
    ovf_o = exp_o > exp_max;
    unf_o = exp_o < exp_min;
  end
endmodule

// File: rtl/fmul_seq.sv
module fmul_seq #(
  parameter int HI_W  = 17,
  parameter int LO_W  = 18,
  parameter int EXP_W = 18
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             float_i,
  input  logic             no_norm_i,
  input  logic             no_round_i,
  input  logic             a_sign_i,
  input  logic [HI_W-1:0]  a_hi_i,
  input  logic [LO_W-1:0]  a_lo_i,
  input  logic [EXP_W-1:0] a_exp_i,
  input  logic             b_sign_i,
  input  logic [HI_W-1:0]  b_hi_i,
  input  logic [LO_W-1:0]  b_lo_i,
  input  logic [EXP_W-1:0] b_exp_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             res_sign_o,
  output logic [HI_W-1:0]  res_hi_o,
  output logic [LO_W-1:0]  res_lo_o,
  output logic [EXP_W-1:0] res_exp_o,
  output logic [HI_W-1:0]  ext_hi_o,
  output logic [LO_W-1:0]  ext_lo_o,
  output logic             guard_o,
  output logic             ovf_o,
  output logic             unf_o
);
  import fmul_pkg::*;

  localparam int FRAC_W = HI_W + LO_W;
  localparam int XW     = EXP_W + 2;
  localparam int CNT_W  = $clog2(FRAC_W);

  fmul_state_e          state_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [FRAC_W-1:0]    acc_q, ext_q, mcand_q;
  logic signed [XW-1:0] exp_q;
  logic                 sign_q, flt_q, nonorm_q, noround_q;
  logic                 done_q, res_sign_q, guard_q, ovf_q, unf_q;
  logic [FRAC_W-1:0]    res_frac_q, res_ext_q;
  logic [EXP_W-1:0]     res_exp_q;

  logic [FRAC_W-1:0]    a_frac, b_frac;
  logic signed [XW-1:0] exp_sum;
  logic [FRAC_W-1:0]    step_acc, step_ext;
  logic                 prod_zero, zero_force, need_shift;
  logic signed [XW-1:0] rnd_exp_in, rnd_exp;
  logic [FRAC_W-1:0]    rnd_frac;
  logic                 rnd_guard, rnd_ovf, rnd_unf;

  assign a_frac  = {a_hi_i, a_lo_i};
  assign b_frac  = {b_hi_i, b_lo_i};
  assign exp_sum = {{2{a_exp_i[EXP_W-1]}}, a_exp_i} + {{2{b_exp_i[EXP_W-1]}}, b_exp_i};

  assign prod_zero  = (acc_q == '0) && (ext_q == '0);
  assign zero_force = !nonorm_q && prod_zero;
  assign need_shift = !nonorm_q && !prod_zero && !acc_q[FRAC_W-1];
  assign rnd_exp_in = zero_force ? '0 : exp_q;

  fmul_step #(.FRAC_W(FRAC_W)) u_step (
    .acc_i   (acc_q),
    .ext_i   (ext_q),
    .mcand_i (mcand_q),
    .acc_o   (step_acc),
    .ext_o   (step_ext)
  );

  fmul_round #(.FRAC_W(FRAC_W), .EXP_W(EXP_W), .XW(XW)) u_round (
    .frac_i     (acc_q),
    .ext_msb_i  (ext_q[FRAC_W-1]),
    .exp_i      (rnd_exp_in),
    .no_round_i (noround_q),
    .frac_o     (rnd_frac),
    .exp_o      (rnd_exp),
    .guard_o    (rnd_guard),
    .ovf_o      (rnd_ovf),
    .unf_o      (rnd_unf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      acc_q      <= '0;
      ext_q      <= '0;
      mcand_q    <= '0;
      exp_q      <= '0;
      sign_q     <= 1'b0;
      flt_q      <= 1'b0;
      nonorm_q   <= 1'b0;
      noround_q  <= 1'b0;
      done_q     <= 1'b0;
      res_sign_q <= 1'b0;
      res_frac_q <= '0;
      res_ext_q  <= '0;
      res_exp_q  <= '0;
      guard_q    <= 1'b0;
      ovf_q      <= 1'b0;
      unf_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            sign_q    <= a_sign_i ^ b_sign_i;
            flt_q     <= float_i;
            nonorm_q  <= no_norm_i;
            noround_q <= no_round_i;
            exp_q     <= float_i ? exp_sum : '0;
            acc_q     <= '0;
            mcand_q   <= b_frac;
            cnt_q     <= '0;
            if (a_frac == '0 || b_frac == '0) begin
              ext_q   <= '0;  // zero operand: skip the iterations
              state_q <= float_i ? ST_NORM : ST_RND;
            end else begin
              ext_q   <= a_frac;
              state_q <= ST_MUL;
            end
          end
        end
        ST_MUL: begin
          acc_q <= step_acc;
          ext_q <= step_ext;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(FRAC_W - 1)) state_q <= flt_q ? ST_NORM : ST_RND;
        end
        ST_NORM: begin
          if (need_shift) begin
            {acc_q, ext_q} <= {acc_q[FRAC_W-2:0], ext_q, 1'b0};
            exp_q          <= exp_q - XW'(1);
          end else begin
            state_q <= ST_RND;
          end
        end
        ST_RND: begin
          done_q  <= 1'b1;
          state_q <= ST_IDLE;
          if (flt_q) begin
            res_sign_q <= zero_force ? 1'b0 : sign_q;
            res_frac_q <= rnd_frac;
            res_ext_q  <= ext_q;
            res_exp_q  <= rnd_exp[EXP_W-1:0];
            guard_q    <= rnd_guard;
            ovf_q      <= rnd_ovf;
            unf_q      <= rnd_unf;
          end else begin
            res_sign_q <= sign_q;
            res_frac_q <= ext_q;
            res_ext_q  <= acc_q;
            res_exp_q  <= '0;
            guard_q    <= 1'b0;
            ovf_q      <= acc_q != '0;
            unf_q      <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = state_q != ST_IDLE;
  assign done_o     = done_q;
  assign res_sign_o = res_sign_q;
  assign res_hi_o   = res_frac_q[FRAC_W-1:LO_W];
  assign res_lo_o   = res_frac_q[LO_W-1:0];
  assign res_exp_o  = res_exp_q;
  assign ext_hi_o   = res_ext_q[FRAC_W-1:LO_W];
  assign ext_lo_o   = res_ext_q[LO_W-1:0];
  assign guard_o    = guard_q;
  assign ovf_o      = ovf_q;
  assign unf_o      = unf_q;
endmodule

// File: rtl/fmul_seq_chk.sv
module fmul_seq_chk #(
  parameter int FRAC_W = 35,
  parameter int EXP_W  = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              busy_i,
  input logic              done_i,
  input logic              flt_i,
  input logic              nonorm_i,
  input logic              sign_i,
  input logic [FRAC_W-1:0] frac_i,
  input logic [FRAC_W-1:0] ext_i,
  input logic [EXP_W-1:0]  exp_i,
  input logic              guard_i,
  input logic              ovf_i,
  input logic              unf_i
);
  // R2
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i) |=> busy_i);

  // R3
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  // R3
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !busy_i);

  // R3
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> $stable({sign_i, frac_i, ext_i, exp_i, guard_i, ovf_i, unf_i}));

  // R6
  int_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && !flt_i) |-> ((ovf_i == (ext_i != '0)) && !unf_i && !guard_i));

  // R7
  normalized_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && flt_i && !nonorm_i && frac_i != '0) |-> frac_i[FRAC_W-1]);

  // R8
  zero_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && flt_i && !nonorm_i && frac_i == '0 && ext_i == '0) |-> (!sign_i && exp_i == '0));

  // R10
  range_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ovf_i && unf_i));
endmodule

bind fmul_seq fmul_seq_chk #(.FRAC_W(HI_W + LO_W), .EXP_W(EXP_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_i   (busy_o),
  .done_i   (done_o),
  .flt_i    (flt_q),
  .nonorm_i (nonorm_q),
  .sign_i   (res_sign_o),
  .frac_i   ({res_hi_o, res_lo_o}),
  .ext_i    ({ext_hi_o, ext_lo_o}),
  .exp_i    (res_exp_o),
  .guard_i  (guard_o),
  .ovf_i    (ovf_o),
  .unf_i    (unf_o)
);

// File: tb/tb_fmul_seq.sv
`timescale 1ns/1ps
module tb_fmul_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, float_i = 1'b0, no_norm_i = 1'b0, no_round_i = 1'b0;
  logic        a_sign_i = 1'b0, b_sign_i = 1'b0;
  logic [16:0] a_hi_i = '0, b_hi_i = '0;
  logic [17:0] a_lo_i = '0, b_lo_i = '0;
  logic [17:0] a_exp_i = '0, b_exp_i = '0;
  logic        busy_o, done_o, res_sign_o, guard_o, ovf_o, unf_o;
  logic [16:0] res_hi_o, ext_hi_o;
  logic [17:0] res_lo_o, ext_lo_o, res_exp_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk_i = ~clk_i;

  fmul_seq dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .float_i(float_i),
    .no_norm_i(no_norm_i), .no_round_i(no_round_i),
    .a_sign_i(a_sign_i), .a_hi_i(a_hi_i), .a_lo_i(a_lo_i), .a_exp_i(a_exp_i),
    .b_sign_i(b_sign_i), .b_hi_i(b_hi_i), .b_lo_i(b_lo_i), .b_exp_i(b_exp_i),
    .busy_o(busy_o), .done_o(done_o), .res_sign_o(res_sign_o),
    .res_hi_o(res_hi_o), .res_lo_o(res_lo_o), .res_exp_o(res_exp_o),
    .ext_hi_o(ext_hi_o), .ext_lo_o(ext_lo_o), .guard_o(guard_o),
    .ovf_o(ovf_o), .unf_o(unf_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  task automatic run(input string name, input bit flt, input bit nn, input bit nr,
                     input bit as, input logic [34:0] fa, input logic [17:0] ea,
                     input bit bs, input logic [34:0] fb, input logic [17:0] eb,
                     input bit intrude);
    logic [69:0] p;
    logic [34:0] e_frac, e_ext;
    logic [17:0] e_expo;
    int e, s, lat;
    bit e_sign, e_guard, e_ovf, e_unf, zero, seen;
    // behavioural reference
    p = {35'd0, fa} * {35'd0, fb};
    zero = (fa == 0) || (fb == 0);
    e_sign = as ^ bs;
    s = 0;
    if (flt) begin
      e = int'($signed(ea)) + int'($signed(eb));
      if (!nn) begin
        if (p == 0) begin e_sign = 0; e = 0; end
        else while (!p[69]) begin p = p << 1; e--; s++; end
      end
      e_frac = p[69:35]; e_ext = p[34:0]; e_guard = p[34];
      if (e_guard && !nr) begin
        if (&e_frac) begin e_frac = 35'h400000000; e++; end
        else e_frac = e_frac + 35'd1;
      end
      e_ovf = e > 131071; e_unf = e < -131072; e_expo = 18'(e);
      lat = zero ? 2 : 37 + s;
    end else begin
      e_frac = p[34:0]; e_ext = p[69:35];
      e_ovf = (e_ext != 0); e_unf = 0; e_guard = 0; e_expo = '0;
      lat = zero ? 1 : 36;
    end
    @(negedge clk_i);
    float_i = flt; no_norm_i = nn; no_round_i = nr;
    a_sign_i = as; a_hi_i = fa[34:18]; a_lo_i = fa[17:0]; a_exp_i = ea;
    b_sign_i = bs; b_hi_i = fb[34:18]; b_lo_i = fb[17:0]; b_exp_i = eb;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk({name, " R2 busy after accept"}, 64'(busy_o), 64'd1);
    seen = 0;
    for (int c = 1; c <= lat; c++) begin
      if (intrude && c == 5) begin
        // R2: a second start while busy must be ignored
        start_i = 1'b1; float_i = ~flt; a_hi_i = 17'h1ABCD; b_lo_i = 18'h2F0F0;
        a_exp_i = 18'h00123; a_sign_i = ~as; no_round_i = ~nr;
      end
      if (intrude && c == 6) start_i = 1'b0;
      @(negedge clk_i);
      // R4 / R3: per-cycle handshake comparison
      chk({name, " R4 done timing"}, 64'(done_o), 64'(c == lat));
      chk({name, " R3 busy"}, 64'(busy_o), 64'(c < lat));
      if (done_o) seen = 1;
      if (seen && c != lat) break;
    end
    chk({name, " R5 sign"}, 64'(res_sign_o), 64'(e_sign));
    chk({name, " R6/R7/R9 frac"}, 64'({res_hi_o, res_lo_o}), 64'(e_frac));
    chk({name, " R6/R7 ext"}, 64'({ext_hi_o, ext_lo_o}), 64'(e_ext));
    chk({name, " R10 exp"}, 64'(res_exp_o), 64'(e_expo));
    chk({name, " R9 guard"}, 64'(guard_o), 64'(e_guard));
    chk({name, " R10 ovf"}, 64'(ovf_o), 64'(e_ovf));
    chk({name, " R10 unf"}, 64'(unf_o), 64'(e_unf));
    @(negedge clk_i);
    chk({name, " R3 done one cycle"}, 64'(done_o), 64'd0);
    chk({name, " R3 hold"}, 64'({res_hi_o, res_lo_o}), 64'(e_frac));
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog R4 actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 busy", 64'(busy_o), 64'd0);
    chk("R1 done", 64'(done_o), 64'd0);
    chk("R1 result", 64'({res_sign_o, res_hi_o, res_lo_o, res_exp_o}), 64'd0);
    chk("R1 ext", 64'({ext_hi_o, ext_lo_o}), 64'd0);
    chk("R1 flags", 64'({guard_o, ovf_o, unf_o}), 64'd0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    run("half*half R7", 1, 0, 0, 0, 35'h400000000, 18'd1, 0, 35'h400000000, 18'd2, 0);
    run("general R5", 1, 0, 0, 1, 35'h5A5A5A5A5, 18'h3FFF9, 0, 35'h3C3C3C3C3, 18'd20, 0);
    run("no-norm R7", 1, 1, 0, 0, 35'h000001234, 18'd4, 1, 35'h000000567, 18'd6, 0);
    run("zero norm R8", 1, 0, 0, 1, 35'h0, 18'd100, 0, 35'h123456789, 18'd3, 0);
    run("zero nonorm R8", 1, 1, 0, 1, 35'h0, 18'd100, 0, 35'h123456789, 18'd3, 0);
    run("round carry R9", 1, 0, 0, 0, 35'h7FFFE0000, 18'd10, 1, 35'h000040001, 18'h3FFFD, 0);
    run("no-round R9", 1, 0, 1, 0, 35'h7FFFE0000, 18'd10, 1, 35'h000040001, 18'h3FFFD, 0);
    run("ones R9", 1, 0, 0, 1, 35'h7FFFFFFFF, 18'd0, 1, 35'h7FFFFFFFF, 18'd0, 0);
    run("overflow R10", 1, 0, 0, 0, 35'h400000000, 18'h1FFFF, 0, 35'h400000000, 18'd5, 0);
    run("underflow R10", 1, 0, 0, 0, 35'h400000000, 18'h20000, 0, 35'h400000000, 18'h3FFF6, 0);
    run("edge max R10", 1, 0, 0, 0, 35'h400000000, 18'h1FFFF, 0, 35'h400000000, 18'd1, 0);
    run("int R6", 0, 0, 0, 0, 35'd1234, 18'd7, 1, 35'd5678, 18'd9, 0);
    run("int ovf R6", 0, 0, 0, 1, 35'h7FFFFFFFF, 18'd0, 1, 35'd3, 18'd0, 0);
    run("int zero R6", 0, 0, 0, 1, 35'h0, 18'd0, 0, 35'd77, 18'd0, 0);
    run("intrude R2", 1, 0, 0, 1, 35'h5A5A5A5A5, 18'h3FFF9, 0, 35'h3C3C3C3C3, 18'd20, 1);
    run("int intrude R2", 0, 0, 0, 0, 35'h00ABCDEF1, 18'd0, 0, 35'h000001F3F, 18'd0, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule